// File: doc/BRIEF.md
# Pilot-Driven Carrier Frequency Tracker

This block follows and removes the residual carrier frequency offset in a spread-spectrum receiver, once the spreading code has been acquired. Despread pilot symbols are summed over a fixed number of symbols. Each sum is placed into one of sixteen angular sectors. The decision needs no arctangent, only the signs of a few linear combinations of the in-phase and quadrature sums.

The sector number changes between two observation periods. That change, taken modulo 16, is folded into a bounded phase step between -4 and +4. The step drives a two-gain loop. The integral gain builds up a frequency word. The proportional gain nudges the phase of a numerically controlled oscillator directly. The frequency word is also added to the oscillator phase once every fixed number of chip samples. The top bits of the oscillator phase address a signed sine/cosine table, and every incoming chip sample is rotated by the conjugate of that table value.

A lock detector counts how often the signs of the corrected I and Q outputs flip over a fixed window of outputs. It reports lock when the count stays under a limit. The tracker is idle while its enable input is low and restarts from a clean state each time it is enabled.

Top module: `pilot_freq_tracker`

## Requirements
- R1: While `en` is low, all state is cleared. From the cycle after, `out_valid`, `sector_valid` and `locked` are 0 and `freq_est` is 0. Inputs applied while disabled leave no trace after re-enabling.
- R2: The sector of a pilot sum (SI, SQ) is found as follows. If SQ<0, or SQ=0 and SI<0, the sum is negated and 8 is added. Then one is added for each of these seven terms that is strictly positive, where x, y are the possibly negated SI, SQ: 2y−x, y−x, y−2x, −x, −2x−y, −x−y, −x−2y. Sectors therefore run 0..15 counterclockwise, with sector 0 starting at the positive I axis.
- R3: Every `PIL_N` accepted pilot symbols (`pil_valid`), `sector_valid` pulses for one cycle, on the clock edge that takes the last symbol of the group. `pilot_sector` then holds the sector of the group's sum, and the sum restarts from zero.
- R4: Take the sector difference d = (new − previous) mod 16. It maps to a step as follows: d=0..4 gives d, d=5..12 gives 8−d, and d=13..15 gives d−16. The first group after enable has no previous sector and gives step 0.
- R5: One cycle after each `sector_valid`, `freq_est` grows by step·2^K1SH. It changes at no other time while enabled.
- R6: The oscillator phase (FW bits, wrapping) grows by step·2^K2SH one cycle after each `sector_valid`. It also grows by the current `freq_est` on every `UPD_CHIPS`-th accepted chip sample. The table address is the top 6 bits of the phase.
- R7: Each accepted chip sample gives `out_valid` one cycle later, with out_i = sat(⌊(I·c + Q·s + 64)/128⌋) and out_q = sat(⌊(Q·c − I·s + 64)/128⌋). Here sat clips to the signed DW-bit range.
- R8: For table address a, c = round(127·cos(2πa/64)) and s = round(127·sin(2πa/64)), as signed 8-bit values.
- R9: Over each window of `LOCK_WIN` outputs, sign changes of out_i and out_q against the previous output are counted. The first output after enable has no predecessor. One cycle after the window's last output, `locked` becomes 1 if the count is at most `LOCK_MAX`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Tracker enable; low clears all state |
| pil_valid | input | 1 | Despread pilot symbol strobe |
| pil_i | input | DW | Pilot symbol, in-phase (signed) |
| pil_q | input | DW | Pilot symbol, quadrature (signed) |
| smp_valid | input | 1 | Chip sample strobe |
| smp_i | input | DW | Chip sample, in-phase (signed) |
| smp_q | input | DW | Chip sample, quadrature (signed) |
| out_valid | output | 1 | Corrected sample strobe |
| out_i | output | DW | Corrected sample, in-phase |
| out_q | output | DW | Corrected sample, quadrature |
| sector_valid | output | 1 | New sector decision |
| pilot_sector | output | 4 | Sector of the last pilot group |
| freq_est | output | FW | Frequency word (signed) |
| locked | output | 1 | Lock indication |

## Verification
The assertions cover four rules on every cycle:
- the idle state while disabled;
- single-cycle sector pulses;
- the frequency word holding still except right after a sector decision;
- corrected outputs and lock changes appearing only one cycle after an accepted input.

Whether sector numbers, folded steps, oscillator phase, table values and rounding are right can only be shown by the bench's scenarios. The bench compares them against a model built from trigonometric functions and the folding table. It does so over directed sector sequences that reach every fold branch, random pilot and sample streams, and lock windows with steady and with alternating signs.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int ROM_AW = 6;

  typedef logic signed [7:0] rom_t;

  function automatic logic [6:0] quarter_mag(input logic [4:0] k);
    logic [6:0] v;
    case (k)
      5'd0:    v = 7'd0;
      5'd1:    v = 7'd12;
      5'd2:    v = 7'd25;
      5'd3:    v = 7'd37;
      5'd4:    v = 7'd49;
      5'd5:    v = 7'd60;
      5'd6:    v = 7'd71;
      5'd7:    v = 7'd81;
      5'd8:    v = 7'd90;
      5'd9:    v = 7'd98;
      5'd10:   v = 7'd106;
      5'd11:   v = 7'd112;
      5'd12:   v = 7'd117;
      5'd13:   v = 7'd122;
      5'd14:   v = 7'd125;
      5'd15:   v = 7'd126;
      default: v = 7'd127;
    endcase
    return v;
  endfunction

  // sine of a 64-step angle built from a quarter wave by symmetry
  function automatic rom_t nco_sin(input logic [ROM_AW-1:0] a);
    logic [4:0] k;
    rom_t m;
    k = a[4] ? (5'd16 - {1'b0, a[3:0]}) : {1'b0, a[3:0]};
    m = $signed({1'b0, quarter_mag(k)});
    return a[5] ? -m : m;
  endfunction

  function automatic rom_t nco_cos(input logic [ROM_AW-1:0] a);
    return nco_sin(a + ROM_AW'(16));
  endfunction

  // fold a mod-16 sector change into a step in -4..4 (R4)
  function automatic logic signed [3:0] fold_step(input logic [3:0] d);
    if (d <= 4'd4)       return $signed(d);
    else if (d <= 4'd12) return $signed(4'd8 - d);
    else                 return $signed(d);
  endfunction
endpackage

// File: rtl/pft_sector.sv
module pft_sector #(
  parameter int AW = 15
) (
  input  logic signed [AW-1:0] acc_i,
  input  logic signed [AW-1:0] acc_q,
  output logic [3:0]           sector
);
  localparam int XW = AW + 3;

  logic signed [XW-1:0] xi, xq, tx, ty;
  logic signed [XW-1:0] proj [7];
  logic [6:0]           beyond;
  logic                 lower;

  always_comb begin
    xi    = XW'(acc_i);
    xq    = XW'(acc_q);
    lower = xq[XW-1] || (xq == '0 && xi[XW-1]);
    tx    = lower ? -xi : xi;
    ty    = lower ? -xq : xq;
    proj[0] = (ty <<< 1) - tx;
    proj[1] = ty - tx;
    proj[2] = ty - (tx <<< 1);
    proj[3] = -tx;
    proj[4] = -(tx <<< 1) - ty;
    proj[5] = -tx - ty;
    proj[6] = -tx - (ty <<< 1);
    for (int k = 0; k < 7; k++) begin
      beyond[k] = !proj[k][XW-1] && (proj[k] != '0);
    end
    sector = {lower, 3'b000} + 4'($countones(beyond));
  end
endmodule

// File: rtl/pft_loop.sv
module pft_loop
  import pft_pkg::*;
#(
  parameter int FW        = 16,
  parameter int K1SH      = 6,
  parameter int K2SH      = 9,
  parameter int UPD_CHIPS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 dump,
  input  logic [3:0]           sector,
  input  logic                 tick,
  output logic signed [FW-1:0] freq,
  output logic [ROM_AW-1:0]    nco_addr
);
  localparam int UCW = $clog2(UPD_CHIPS);

  logic [3:0]           prev_q, prev_d;
  logic                 have_q, have_d;
  logic signed [FW-1:0] freq_q, freq_d, prop;
  logic [FW-1:0]        phase_q, phase_d;
  logic [UCW-1:0]       ucnt_q, ucnt_d;
  logic signed [3:0]    step;
  logic                 roll;

  always_comb begin
    step    = have_q ? fold_step(sector - prev_q) : 4'sd0;
    prev_d  = prev_q;
    have_d  = have_q;
    freq_d  = freq_q;
    phase_d = phase_q;
    ucnt_d  = ucnt_q;
    roll    = 1'b0;
    prop    = '0;
    if (!en) begin
      prev_d  = '0;
      have_d  = 1'b0;
      freq_d  = '0;
      phase_d = '0;
      ucnt_d  = '0;
    end else begin
      if (dump) begin
        prev_d = sector;
        have_d = 1'b1;
        freq_d = freq_q + (FW'(step) <<< K1SH);
        prop   = FW'(step) <<< K2SH;
      end
      if (tick) begin
        if (ucnt_q == UCW'(UPD_CHIPS - 1)) begin
          ucnt_d = '0;
          roll   = 1'b1;
        end else begin
          ucnt_d = ucnt_q + 1'b1;
        end
      end
      phase_d = phase_q + $unsigned(prop) + (roll ? $unsigned(freq_q) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      freq_q  <= '0;
      phase_q <= '0;
      ucnt_q  <= '0;
    end else begin
      prev_q  <= prev_d;
      have_q  <= have_d;
      freq_q  <= freq_d;
      phase_q <= phase_d;
      ucnt_q  <= ucnt_d;
    end
  end

  assign freq     = freq_q;
  assign nco_addr = phase_q[FW-1 -: ROM_AW];
endmodule

// File: rtl/pft_rotator.sv
module pft_rotator
  import pft_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [DW-1:0] smp_q,
  input  logic [ROM_AW-1:0]    addr,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int PW = DW + 10;

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v[PW-1:DW-1] == '0 || v[PW-1:DW-1] == '1) return v[DW-1:0];
    else if (v[PW-1]) return {1'b1, {(DW-1){1'b0}}};
    else return {1'b0, {(DW-1){1'b1}}};
  endfunction

  rom_t                 cs, sn;
  logic signed [PW-1:0] pr_i, pr_q;
  logic                 ov_q, ov_d;
  logic signed [DW-1:0] oi_q, oi_d, oq_q, oq_d;

  always_comb begin
    cs   = nco_cos(addr);
    sn   = nco_sin(addr);
    pr_i = PW'(smp_i) * PW'(cs) + PW'(smp_q) * PW'(sn) + PW'(64);
    pr_q = PW'(smp_q) * PW'(cs) - PW'(smp_i) * PW'(sn) + PW'(64);
    ov_d = en && smp_valid;
    oi_d = oi_q;
    oq_d = oq_q;
    if (!en) begin
      oi_d = '0;
      oq_d = '0;
    end else if (smp_valid) begin
      oi_d = clip(pr_i >>> 7);
      oq_d = clip(pr_q >>> 7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      oi_q <= '0;
      oq_q <= '0;
    end else begin
      ov_q <= ov_d;
      oi_q <= oi_d;
      oq_q <= oq_d;
    end
  end

  assign out_valid = ov_q;
  assign out_i     = oi_q;
  assign out_q     = oq_q;
endmodule

// File: rtl/pft_lock.sv
module pft_lock #(
  parameter int LOCK_WIN = 64,
  parameter int LOCK_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic v,
  input  logic sign_i,
  input  logic sign_q,
  output logic locked
);
  localparam int WCW = $clog2(LOCK_WIN);
  localparam int CCW = $clog2(2 * LOCK_WIN + 1);

  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic [CCW-1:0] chg_q, chg_d, nchg, tot;
  logic           psi_q, psi_d, psq_q, psq_d, hp_q, hp_d, lock_q, lock_d;

  always_comb begin
    nchg   = hp_q ? (CCW'(sign_i ^ psi_q) + CCW'(sign_q ^ psq_q)) : '0;
    tot    = chg_q + nchg;
    wcnt_d = wcnt_q;
    chg_d  = chg_q;
    psi_d  = psi_q;
    psq_d  = psq_q;
    hp_d   = hp_q;
    lock_d = lock_q;
    if (!en) begin
      wcnt_d = '0;
      chg_d  = '0;
      psi_d  = 1'b0;
      psq_d  = 1'b0;
      hp_d   = 1'b0;
      lock_d = 1'b0;
    end else if (v) begin
      psi_d = sign_i;
      psq_d = sign_q;
      hp_d  = 1'b1;
      if (wcnt_q == WCW'(LOCK_WIN - 1)) begin
        wcnt_d = '0;
        chg_d  = '0;
        lock_d = (tot <= CCW'(LOCK_MAX));
      end else begin
        wcnt_d = wcnt_q + 1'b1;
        chg_d  = tot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      chg_q  <= '0;
      psi_q  <= 1'b0;
      psq_q  <= 1'b0;
      hp_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      chg_q  <= chg_d;
      psi_q  <= psi_d;
      psq_q  <= psq_d;
      hp_q   <= hp_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/pilot_freq_tracker.sv
module pilot_freq_tracker
  import pft_pkg::*;
#(
  parameter int DW        = 12,
  parameter int PIL_N     = 4,
  parameter int FW        = 16,
  parameter int K1SH      = 6,
  parameter int K2SH      = 9,
  parameter int UPD_CHIPS = 128,
  parameter int LOCK_WIN  = 64,
  parameter int LOCK_MAX  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 pil_valid,
  input  logic signed [DW-1:0] pil_i,
  input  logic signed [DW-1:0] pil_q,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [DW-1:0] smp_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic                 sector_valid,
  output logic [3:0]           pilot_sector,
  output logic signed [FW-1:0] freq_est,
  output logic                 locked
);
  localparam int PCW = $clog2(PIL_N);
  localparam int AW  = DW + PCW + 1;

  logic [1:0]           rsync_q;
  logic                 rst_int_n;
  logic signed [AW-1:0] pacc_i_q, pacc_i_d, pacc_q_q, pacc_q_d, sum_i, sum_q;
  logic [PCW-1:0]       pcnt_q, pcnt_d;
  logic [3:0]           sec_now, sec_q, sec_d;
  logic                 svld_q, svld_d;
  logic [ROM_AW-1:0]    nco_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign sum_i = pacc_i_q + AW'(pil_i);
  assign sum_q = pacc_q_q + AW'(pil_q);

  pft_sector #(.AW(AW)) u_sector (
    .acc_i  (sum_i),
    .acc_q  (sum_q),
    .sector (sec_now)
  );

  always_comb begin
    pacc_i_d = pacc_i_q;
    pacc_q_d = pacc_q_q;
    pcnt_d   = pcnt_q;
    sec_d    = sec_q;
    svld_d   = 1'b0;
    if (!en) begin
      pacc_i_d = '0;
      pacc_q_d = '0;
      pcnt_d   = '0;
      sec_d    = '0;
    end else if (pil_valid) begin
      if (pcnt_q == PCW'(PIL_N - 1)) begin
        pacc_i_d = '0;
        pacc_q_d = '0;
        pcnt_d   = '0;
        sec_d    = sec_now;
        svld_d   = 1'b1;
      end else begin
        pacc_i_d = sum_i;
        pacc_q_d = sum_q;
        pcnt_d   = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pacc_i_q <= '0;
      pacc_q_q <= '0;
      pcnt_q   <= '0;
      sec_q    <= '0;
      svld_q   <= 1'b0;
    end else begin
      pacc_i_q <= pacc_i_d;
      pacc_q_q <= pacc_q_d;
      pcnt_q   <= pcnt_d;
      sec_q    <= sec_d;
      svld_q   <= svld_d;
    end
  end

  assign sector_valid = svld_q;
  assign pilot_sector = sec_q;

  pft_loop #(.FW(FW), .K1SH(K1SH), .K2SH(K2SH), .UPD_CHIPS(UPD_CHIPS)) u_loop (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (en),
    .dump     (svld_q),
    .sector   (sec_q),
    .tick     (smp_valid),
    .freq     (freq_est),
    .nco_addr (nco_addr)
  );

  pft_rotator #(.DW(DW)) u_rot (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (en),
    .smp_valid (smp_valid),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .addr      (nco_addr),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  pft_lock #(.LOCK_WIN(LOCK_WIN), .LOCK_MAX(LOCK_MAX)) u_lock (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (en),
    .v      (out_valid),
    .sign_i (out_i[DW-1]),
    .sign_q (out_q[DW-1]),
    .locked (locked)
  );
endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          smp_valid,
  input logic          out_valid,
  input logic          sector_valid,
  input logic [FW-1:0] freq_est,
  input logic          locked
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_valid && !sector_valid && !locked && freq_est == '0));

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sector_valid |=> !sector_valid);

  p_freq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(sector_valid)) |-> $stable(freq_est));

  p_out_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(smp_valid) && $past(en)));

  p_lock_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $changed(locked)) |-> $past(out_valid));
endmodule

bind pilot_freq_tracker pft_checker #(.FW(FW)) i_pft_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .smp_valid    (smp_valid),
  .out_valid    (out_valid),
  .sector_valid (sector_valid),
  .freq_est     (freq_est),
  .locked       (locked)
);

// File: tb/test_pilot_freq_tracker.sv
module test_pilot_freq_tracker;
  localparam int DW = 12;
  localparam int PIL_N = 4;
  localparam int FW = 16;
  localparam int UPD = 128;
  localparam int WIN = 64;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic pil_valid = 1'b0, smp_valid = 1'b0;
  logic signed [DW-1:0] pil_i = '0, pil_q = '0, smp_i = '0, smp_q = '0;
  logic out_valid, sector_valid, locked;
  logic signed [DW-1:0] out_i, out_q;
  logic [3:0] pilot_sector;
  logic signed [FW-1:0] freq_est;

  int checks = 0, errors = 0;
  logic [15:0] m_ph;
  logic signed [15:0] m_fr;
  int m_cnt, m_prev;
  bit m_have;

  always #2 clk = ~clk;

  pilot_freq_tracker i_pilot_freq_tracker (
    .clk(clk), .rst_n(rst_n), .en(en), .pil_valid(pil_valid), .pil_i(pil_i), .pil_q(pil_q),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .sector_valid(sector_valid), .pilot_sector(pilot_sector),
    .freq_est(freq_est), .locked(locked)
  );

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int fold_model(input int d);
    if (d <= 4) return d;
    if (d <= 8) return 8 - d;
    if (d <= 12) return -(d - 8);
    return d - 16;
  endfunction

  function automatic int clip(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ph = '0; m_fr = '0; m_cnt = 0; m_prev = 0; m_have = 0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); en = v;
    if (!v) model_clear();
    @(negedge clk);
  endtask

  // one group of PIL_N pilots pointing into the middle of sector idx
  task automatic pilot_group(input int idx);
    real ang;
    int st;
    ang = (idx * 22.5 + 11.25) * PI / 180.0;
    for (int k = 0; k < PIL_N; k++) begin
      @(negedge clk);
      pil_valid = 1'b1;
      pil_i = DW'(rnd(300.0 * $cos(ang)));
      pil_q = DW'(rnd(300.0 * $sin(ang)));
      @(posedge clk); #1;
      pil_valid = 1'b0;
      if (k < PIL_N - 1) check(!sector_valid, "R3 early pulse", int'(sector_valid), 0);
    end
    check(sector_valid && pilot_sector == 4'(idx), "R2/R3 sector", int'(pilot_sector), idx);
    st = m_have ? fold_model((idx - m_prev + 16) % 16) : 0;
    m_fr = m_fr + 16'(st * 64);
    m_ph = m_ph + 16'(st * 512);
    m_prev = idx; m_have = 1;
    @(posedge clk); #1;
    check(freq_est == m_fr, "R4/R5 freq_est", int'(freq_est), int'(m_fr));
    check(!sector_valid, "R3 single pulse", int'(sector_valid), 0);
    @(negedge clk);
  endtask

  task automatic sample(input int si, input int sq);
    int a, c, s, ei, eq;
    a = int'(m_ph[15:10]);
    c = rnd(127.0 * $cos(2.0 * PI * a / 64.0));
    s = rnd(127.0 * $sin(2.0 * PI * a / 64.0));
    ei = clip((si * c + sq * s + 64) >>> 7);
    eq = clip((sq * c - si * s + 64) >>> 7);
    @(negedge clk);
    smp_valid = 1'b1; smp_i = DW'(si); smp_q = DW'(sq);
    @(posedge clk); #1;
    smp_valid = 1'b0;
    check(out_valid && out_i == DW'(ei) && out_q == DW'(eq), "R6/R7/R8 rotation",
          int'(out_i), ei);
    m_cnt++;
    if (m_cnt == UPD) begin m_cnt = 0; m_ph = m_ph + 16'(m_fr); end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed, r;
    seed = $urandom(1234);
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !sector_valid && !locked && freq_est == 0, "R1 reset state", int'(freq_est), 0);

    // R1: disabled tracker ignores pilots and samples
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pil_valid = 1'b1; smp_valid = 1'b1; pil_i = 12'sd500; smp_i = 12'sd400;
      @(posedge clk); #1; pil_valid = 1'b0; smp_valid = 1'b0;
      check(!out_valid && !sector_valid && freq_est == 0, "R1 idle while disabled", int'(out_valid), 0);
    end
    set_en(1);
    // R9: steady signs give lock
    for (int k = 0; k < WIN; k++) sample(500, 300);
    @(posedge clk); #1;
    check(locked == 1'b1, "R9 steady window locks", int'(locked), 1);
    // R9: alternating signs drop lock
    for (int k = 0; k < WIN; k++) sample((k % 2) ? -500 : 500, (k % 2) ? -300 : 300);
    @(posedge clk); #1;
    check(locked == 1'b0, "R9 flipping window unlocks", int'(locked), 0);

    // R1: re-enable clears the history
    set_en(0);
    set_en(1);
    check(!locked && freq_est == 0, "R1 clean restart", int'(locked), 0);
    pilot_group(3);   // first group: step 0 (R4)
    // R2, R4: sweep of all sectors and every fold branch
    pilot_group(0); pilot_group(5); pilot_group(13); pilot_group(1); pilot_group(0);
    pilot_group(15); pilot_group(6); pilot_group(15); pilot_group(4); pilot_group(8);
    pilot_group(12); pilot_group(2); pilot_group(7); pilot_group(9); pilot_group(10);
    pilot_group(11); pilot_group(14);
    for (int k = 0; k < 150; k++) sample(2047, -2048);

    // random pilots and full-range samples (R6, R7, R8)
    for (int it = 0; it < 30; it++) begin
      pilot_group(int'($urandom % 16));
      r = 20 + int'($urandom % 60);
      for (int k = 0; k < r; k++)
        sample(int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048);
    end
    for (int k = 0; k < 4; k++) begin
      sample(2047, 2047); sample(-2048, -2048); sample(-2048, 2047);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule